// File: doc/BRIEF.md
# Masked GPIO Port Register File

This block is one 32-bit general-purpose I/O port behind a small synchronous register bus. Software chooses a direction for each pin, drives output levels and samples input levels. It can also act on any group of pins in a single bus access. A mask register limits which bits an access may touch. Two write-only strobe registers force chosen output bits high or low without a read-modify-write sequence.

Every writable register honours per-byte enables, so byte, half-word and word accesses behave the same way on each lane. Pin inputs are brought into the clock domain through a two-flop synchroniser before any read can see them. Read data is registered and appears one clock after the request.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset the direction, mask and output registers are all zero, `pin_oe` is all zero, `pin_out` is all zero, and reads of the direction, mask and set registers return zero.
- R2: The direction register at offset 0x00 reads back what was written, and `pin_oe[i]` equals direction bit i (1 = output).
- R3: `pin_out[i]` carries output register bit i while direction bit i is 1, and is 0 while direction bit i is 0.
- R4: On a write, bus_be[k] gates bits 8k+7..8k of the addressed register. A write with every byte enable low changes nothing.
- R5: The mask register at offset 0x10 reads back what was written. A mask bit of 1 excludes that bit from pin-value writes, set writes and clear writes.
- R6: A write to the pin-value register at offset 0x14 loads every included, lane-enabled output bit from write data in one access, and leaves all other output bits unchanged.
- R7: A read of the pin-value register returns the synchronised pin inputs, with every masked bit read as 0.
- R8: A pin change applied before clock edge k is first seen by a read request sampled at edge k+2. Read requests sampled at edges k and k+1 still return the old level.
- R9: A write to the set register at offset 0x18 sets each output bit whose write-data bit is 1, provided the bit is included and its lane is enabled. Zero bits have no effect. A read of 0x18 returns the output register.
- R10: A write to the clear register at offset 0x1C clears each output bit whose write-data bit is 1, provided the bit is included and its lane is enabled. Zero bits have no effect. A read of 0x1C returns 0.
- R11: Reads of any other offset return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one clock after a read request |
| pin_in | input | 32 | Raw pin levels (asynchronous) |
| pin_out | output | 32 | Output levels towards the pads |
| pin_oe | output | 32 | Per-pin output enable |

## Verification
The bench writes through a partially set mask and checks that the masked output bits keep their values. A design that ignored the mask there would clear or overwrite them. Single-lane set and clear writes show whether the byte enables are honoured: an ungated design would change all four bytes. The synchroniser latency is checked with back-to-back reads right after a pin change. Too few stages would return the new level one read early, and extra stages would return the old level one read too late. Unmapped offsets and all-lanes-off writes are also driven, to catch decoders that alias onto a real register.

// File: rtl/gpio_mask_port.sv
module gpio_mask_port #(
  parameter int WIDTH = 32,
  parameter int AW    = 5,
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [WIDTH/8-1:0] bus_be,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe
);
  localparam int LANES = WIDTH / 8;
  localparam logic [AW-1:0] OFF_DIR = AW'(8'h00);
  localparam logic [AW-1:0] OFF_MSK = AW'(8'h10);
  localparam logic [AW-1:0] OFF_PIN = AW'(8'h14);
  localparam logic [AW-1:0] OFF_SET = AW'(8'h18);
  localparam logic [AW-1:0] OFF_CLR = AW'(8'h1C);

  logic [WIDTH-1:0] dir_q, mask_q, out_q, rdata_q;
  logic [WIDTH-1:0] sync_q [SYNC];
  logic [WIDTH-1:0] lane_bits, sel_bits, pin_vis;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_bits[8*g +: 8] = {8{bus_be[g]}};
  end

  wire wr_any  = bus_sel & bus_wr;
  wire rd_any  = bus_sel & ~bus_wr;
  wire hit_dir = wr_any && (bus_addr == OFF_DIR);
  wire hit_msk = wr_any && (bus_addr == OFF_MSK);
  wire hit_pin = wr_any && (bus_addr == OFF_PIN);
  wire hit_set = wr_any && (bus_addr == OFF_SET);
  wire hit_clr = wr_any && (bus_addr == OFF_CLR);

  assign sel_bits = lane_bits & ~mask_q;
  assign pin_vis  = sync_q[SYNC-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= pin_in;
      for (int i = 1; i < SYNC; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q  <= '0;
      mask_q <= '0;
      out_q  <= '0;
    end else begin
      if (hit_dir) dir_q  <= (dir_q  & ~lane_bits) | (bus_wdata & lane_bits);
      if (hit_msk) mask_q <= (mask_q & ~lane_bits) | (bus_wdata & lane_bits);
      if (hit_pin)      out_q <= (out_q & ~sel_bits) | (bus_wdata & sel_bits);
      else if (hit_set) out_q <= out_q | (bus_wdata & sel_bits);
      else if (hit_clr) out_q <= out_q & ~(bus_wdata & sel_bits);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata_q <= '0;
    else if (rd_any) begin
      case (bus_addr)
        OFF_DIR: rdata_q <= dir_q;
        OFF_MSK: rdata_q <= mask_q;
        OFF_PIN: rdata_q <= pin_vis & ~mask_q;
        OFF_SET: rdata_q <= out_q;
        default: rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
  assign pin_oe    = dir_q;
  assign pin_out   = out_q & dir_q;
endmodule

module gpio_mask_port_chk #(
  parameter int WIDTH = 32,
  parameter int AW    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [AW-1:0]    bus_addr,
  input logic [WIDTH/8-1:0] bus_be,
  input logic [WIDTH-1:0] bus_wdata,
  input logic [WIDTH-1:0] bus_rdata,
  input logic [WIDTH-1:0] pin_out,
  input logic [WIDTH-1:0] pin_oe,
  input logic [WIDTH-1:0] mask_q,
  input logic [WIDTH-1:0] out_q
);
  localparam logic [AW-1:0] C_PIN = AW'(8'h14);
  localparam logic [AW-1:0] C_SET = AW'(8'h18);
  localparam logic [AW-1:0] C_CLR = AW'(8'h1C);

  p_reset_oe_r1: assert property (@(posedge clk) $rose(rst_n) |-> (pin_oe == '0 && pin_out == '0));

  p_dir_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr) |=> $stable(pin_oe));

  p_no_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_be == '0) |=> ($stable(pin_oe) && $stable(out_q)));

  p_mask_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == C_PIN) |=> (((out_q ^ $past(out_q)) & $past(mask_q)) == '0));

  p_set_hits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == C_SET && bus_be == '1) |=>
    ((pin_out & $past(bus_wdata & ~mask_q & pin_oe)) == $past(bus_wdata & ~mask_q & pin_oe)));

  p_clr_hits_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == C_CLR && bus_be == '1) |=>
    ((out_q & $past(bus_wdata & ~mask_q)) == '0));

  p_clr_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == C_CLR) |=> (bus_rdata == '0));
endmodule

bind gpio_mask_port gpio_mask_port_chk #(.WIDTH(WIDTH), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .pin_out(pin_out), .pin_oe(pin_oe),
  .mask_q(mask_q), .out_q(out_q)
);

// File: tb/gpio_mask_port_tb_top.sv
`timescale 1ns/1ps
module gpio_mask_port_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [4:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, pin_in = '0, pin_out, pin_oe;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  gpio_mask_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [3:0] be, logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_be = '0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 pin_oe", pin_oe, 32'h0);
    chk("R1 pin_out", pin_out, 32'h0);
    rd(5'h00, v); chk("R1 dir", v, 32'h0);
    rd(5'h10, v); chk("R1 mask", v, 32'h0);
    rd(5'h18, v); chk("R1 out", v, 32'h0);
  endtask

  task automatic t_dir();
    logic [31:0] v;
    wr(5'h00, 4'hF, 32'hFFFF0000);
    rd(5'h00, v); chk("R2 dir readback", v, 32'hFFFF0000);
    chk("R2 pin_oe", pin_oe, 32'hFFFF0000);
    wr(5'h00, 4'b0001, 32'h123456FF);
    chk("R4 byte lane dir", pin_oe, 32'hFFFF00FF);
    wr(5'h00, 4'b0000, 32'h00000000);
    chk("R4 no lanes dir", pin_oe, 32'hFFFF00FF);
  endtask

  task automatic t_outgate();
    logic [31:0] v;
    wr(5'h00, 4'hF, 32'h0000FFFF);
    wr(5'h14, 4'hF, 32'hFFFFFFFF);
    rd(5'h18, v); chk("R6 full word write", v, 32'hFFFFFFFF);
    chk("R3 pin_out gated", pin_out, 32'h0000FFFF);
    wr(5'h00, 4'hF, 32'hFFFFFFFF);
    chk("R3 pin_out all out", pin_out, 32'hFFFFFFFF);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(5'h10, 4'hF, 32'hFF00FF00);
    rd(5'h10, v); chk("R5 mask readback", v, 32'hFF00FF00);
    wr(5'h14, 4'hF, 32'h00000000);
    chk("R5 R6 masked pin write", pin_out, 32'hFF00FF00);
    wr(5'h18, 4'hF, 32'h0F0F0F0F);
    chk("R5 R9 masked set", pin_out, 32'hFF0FFF0F);
    wr(5'h1C, 4'hF, 32'hFFFFFFFF);
    chk("R5 R10 masked clear", pin_out, 32'hFF00FF00);
    wr(5'h10, 4'hF, 32'h0);
  endtask

  task automatic t_setclr();
    logic [31:0] v;
    wr(5'h14, 4'hF, 32'h0);
    wr(5'h18, 4'b0010, 32'hFFFFFFFF);
    chk("R9 R4 set one lane", pin_out, 32'h0000FF00);
    wr(5'h18, 4'hF, 32'h0);
    chk("R9 set zeros", pin_out, 32'h0000FF00);
    wr(5'h1C, 4'hF, 32'h00000F00);
    chk("R10 clear", pin_out, 32'h0000F000);
    wr(5'h1C, 4'hF, 32'h0);
    chk("R10 clear zeros", pin_out, 32'h0000F000);
    rd(5'h1C, v); chk("R10 clear reads zero", v, 32'h0);
    rd(5'h18, v); chk("R9 set reads out", v, 32'h0000F000);
  endtask

  task automatic t_pinread();
    logic [31:0] v;
    pin_in = 32'h12345678;
    repeat (4) @(negedge clk);
    rd(5'h14, v); chk("R7 pin read", v, 32'h12345678);
    wr(5'h10, 4'hF, 32'hFFFF0000);
    rd(5'h14, v); chk("R7 pin read masked", v, 32'h00005678);
    wr(5'h10, 4'hF, 32'h0);
  endtask

  task automatic t_sync();
    logic [31:0] v0, v1, v2;
    pin_in = 32'hCAFEF00D;
    rd(5'h14, v0);
    rd(5'h14, v1);
    rd(5'h14, v2);
    chk("R8 edge k", v0, 32'h12345678);
    chk("R8 edge k+1", v1, 32'h12345678);
    chk("R8 edge k+2", v2, 32'hCAFEF00D);
  endtask

  task automatic t_unmapped();
    logic [31:0] v, oe0, po0;
    oe0 = pin_oe; po0 = pin_out;
    wr(5'h04, 4'hF, 32'hFFFFFFFF);
    wr(5'h0C, 4'hF, 32'h00000000);
    chk("R11 oe untouched", pin_oe, oe0);
    chk("R11 out untouched", pin_out, po0);
    rd(5'h04, v); chk("R11 read 0x04", v, 32'h0);
    rd(5'h0C, v); chk("R11 read 0x0C", v, 32'h0);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_dir();
    t_outgate();
    t_mask();
    t_setclr();
    t_pinread();
    t_sync();
    t_unmapped();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule